// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block sits on the host side of a serial flash link and turns one erase request into the full bus conversation that a NOR flash expects. A request carries a 24-bit address and a flag that selects a small-region erase or a large-region erase. After the request is accepted, the sequencer performs three steps, each in its own chip-select window. It first sends a write-enable command. It then sends a 32-bit erase frame: the opcode followed by the address, most significant bit first. Finally it polls the flash status register until the busy flag reads clear.

The bus runs in SPI mode 0. The clock rests low, the host changes its data output on falling edges, and both sides sample on rising edges. The host keeps chip-select high for a minimum number of system cycles between two windows. The flash starts the internal erase when chip-select rises at the end of the erase frame. A poll budget guards against a flash that never finishes. When the budget runs out, the sequencer raises a sticky error flag and returns to idle without signalling completion.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sck is low, req_ready is high, and done and err are low.
- R2: A request is taken when req_valid and req_ready are both high at a clock edge. req_ready then stays low until the whole sequence has ended, and req_valid asserted while req_ready is low has no effect.
- R3: The first chip-select window of a sequence carries exactly 8 clock pulses with the write-enable opcode 0x06. It comes before the erase frame.
- R4: The second window carries exactly 32 clock pulses. The first 8 bits are the opcode: 0x20 when req_block is 0, or the BLOCK_OPCODE parameter (default 0xD8) when req_block is 1. The last 24 bits are req_addr, from bit 23 down to bit 0.
- R5: Each status poll is one window of exactly 16 clock pulses. The first 8 bits carry the opcode 0x05. During the last 8 pulses spi_so is sampled on rising edges, most significant bit first, and the last bit sampled (status bit 0) is the busy flag.
- R6: spi_sck is low whenever spi_cs_n is high. spi_si does not change while spi_sck is high.
- R7: Between two consecutive windows, spi_cs_n stays high for at least CS_GAP clock cycles.
- R8: When a poll returns busy = 0, done is high for exactly one cycle, err stays low, and no further window follows in that sequence.
- R9: If MAX_POLLS polls in a row all return busy = 1, err goes high, done does not pulse, and the sequence ends with no further window. err stays high until the next request is accepted, and it is low from the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_block | input | 1 | 0 selects the small-region erase opcode, 1 selects the large-region opcode |
| req_addr | input | 24 | Flash byte address of the region to erase |
| done | output | 1 | One-cycle pulse when the flash reports the erase finished |
| err | output | 1 | Sticky flag: the poll budget was used up |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_si | output | 1 | Serial data from host to flash |
| spi_so | input | 1 | Serial data from flash to host |

## Verification
The bench pairs the sequencer with a behavioural flash model. The model decodes every chip-select window by length and opcode, tracks a write-enable latch, and reports busy for a chosen number of polls. The corner cases are these:
- An erase frame with no write-enable before it would show up as an erase received with the latch clear.
- An opcode or address bit that is out of order would show up as a wrong opcode or address.
- A chip-select gap that is too short would be caught by a cycle count of every high period.
- An off-by-one in the poll budget would change the number of status reads before err.
- A sequencer that accepts requests while busy would erase twice or at the wrong address.
- If err did not clear when the next request is accepted, a good sequence would report a stale error.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    localparam int ADDR_W  = 24;
    localparam int FRAME_W = 32;
    localparam int NBITS_W = $clog2(FRAME_W + 1);

    localparam logic [7:0] CMD_WRITE_EN  = 8'h06;
    localparam logic [7:0] CMD_SMALL_ERS = 8'h20;
    localparam logic [7:0] CMD_READ_STAT = 8'h05;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_GAP    = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_WREN  = 2'd0,
        STEP_ERASE = 2'd1,
        STEP_POLL  = 2'd2,
        STEP_END   = 2'd3
    } seq_step_e;

endpackage

// File: rtl/erase_gap_timer.sv
module erase_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(GAP - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: a fresh load always leaves the counter at its top value next cycle
    p_gap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == CNT_W'(GAP - 1)));

endmodule

// File: rtl/erase_spi_shifter.sv
module erase_spi_shifter
    import erase_seq_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NBITS_W-1:0] nbits_i,
    input  logic [FRAME_W-1:0] tx_i,
    input  logic               so_i,
    output logic               sck_o,
    output logic               si_o,
    output logic               done_o,
    output logic               last_bit_o
);
    localparam int TMR_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic               active;
        logic               sck;
        logic [TMR_W-1:0]   timer;
        logic [NBITS_W-1:0] bits;
        logic [FRAME_W-1:0] shreg;
        logic               rx;
        logic               done;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.sck    = 1'b0;
                d.timer  = TMR_W'(HALF_DIV - 1);
                d.bits   = nbits_i;
                d.shreg  = tx_i;
                d.rx     = 1'b0;
            end
        end else if (q.timer != '0) begin
            d.timer = q.timer - 1'b1;
        end else begin
            d.timer = TMR_W'(HALF_DIV - 1);
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = so_i;
            end else begin
                d.sck   = 1'b0;
                d.shreg = {q.shreg[FRAME_W-2:0], 1'b0};
                d.bits  = q.bits - 1'b1;
                if (q.bits == NBITS_W'(1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o      = q.sck;
    assign si_o       = q.shreg[FRAME_W-1];
    assign done_o     = q.done;
    assign last_bit_o = q.rx;

    // R6: data out holds steady across the whole high phase of the clock
    p_si_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sck && $past(q.sck)) |-> $stable(q.shreg[FRAME_W-1]));

    // R6: the clock never stays high once the frame has ended
    p_sck_low_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.sck);

    // R5: an active frame always has bits left to send
    p_bits_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.bits != '0));

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int         HALF_DIV     = 2,
    parameter int         CS_GAP       = 4,
    parameter int         MAX_POLLS    = 8,
    parameter logic [7:0] BLOCK_OPCODE = 8'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_block,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              err,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_si,
    input  logic              spi_so
);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam int RUN_W  = $clog2(CS_GAP + 1);

    typedef struct packed {
        seq_state_e        state;
        seq_step_e         step;
        logic              cs_n;
        logic [ADDR_W-1:0] addr;
        logic              block;
        logic [POLL_W-1:0] polls;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t d, q;

    logic               shift_start;
    logic               shift_done;
    logic               busy_bit;
    logic               gap_load;
    logic               gap_expired;
    logic [NBITS_W-1:0] frame_bits;
    logic [FRAME_W-1:0] frame_data;

    // frame contents for the current step
    always_comb begin
        unique case (q.step)
            STEP_WREN: begin
                frame_bits = NBITS_W'(8);
                frame_data = {CMD_WRITE_EN, {(FRAME_W-8){1'b0}}};
            end
            STEP_ERASE: begin
                frame_bits = NBITS_W'(FRAME_W);
                frame_data = {(q.block ? BLOCK_OPCODE : CMD_SMALL_ERS), q.addr};
            end
            default: begin
                frame_bits = NBITS_W'(16);
                frame_data = {CMD_READ_STAT, {(FRAME_W-8){1'b0}}};
            end
        endcase
    end

    // sequencing
    always_comb begin
        d           = q;
        d.done      = 1'b0;
        shift_start = 1'b0;
        gap_load    = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.block = req_block;
                    d.polls = '0;
                    d.err   = 1'b0;
                    d.step  = STEP_WREN;
                    d.cs_n  = 1'b0;
                    d.state = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                shift_start = 1'b1;
                d.state     = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (shift_done) begin
                    d.cs_n   = 1'b1;
                    gap_load = 1'b1;
                    d.state  = ST_GAP;
                    unique case (q.step)
                        STEP_WREN:  d.step = STEP_ERASE;
                        STEP_ERASE: d.step = STEP_POLL;
                        default: begin
                            if (!busy_bit) begin
                                d.done = 1'b1;
                                d.step = STEP_END;
                            end else if (q.polls == POLL_W'(MAX_POLLS - 1)) begin
                                d.err  = 1'b1;
                                d.step = STEP_END;
                            end else begin
                                d.polls = q.polls + 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (gap_expired) begin
                    if (q.step == STEP_END) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.cs_n  = 1'b0;
                        d.state = ST_LAUNCH;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.step  <= STEP_END;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    erase_spi_shifter #(
        .HALF_DIV (HALF_DIV)
    ) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (shift_start),
        .nbits_i    (frame_bits),
        .tx_i       (frame_data),
        .so_i       (spi_so),
        .sck_o      (spi_sck),
        .si_o       (spi_si),
        .done_o     (shift_done),
        .last_bit_o (busy_bit)
    );

    erase_gap_timer #(
        .GAP (CS_GAP)
    ) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (gap_load),
        .expired_o (gap_expired)
    );

    assign req_ready = (q.state == ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign spi_cs_n  = q.cs_n;

    // high-time tracker used only by the gap assertion
    logic [RUN_W-1:0] hi_run_d, hi_run_q;

    always_comb begin
        hi_run_d = hi_run_q;
        if (!q.cs_n)                          hi_run_d = '0;
        else if (hi_run_q != RUN_W'(CS_GAP))  hi_run_d = hi_run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_run_q <= RUN_W'(CS_GAP);
        else        hi_run_q <= hi_run_d;
    end

    // R7: every falling chip-select follows a full minimum high period
    p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_run_q == RUN_W'(CS_GAP)));

    // R6: clock is parked low outside chip-select windows
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R2: the request side is only open while the bus is deselected
    p_ready_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    // R8: completion lasts a single cycle and never together with an error
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    // R9: error holds until a new request is taken
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(req_valid && req_ready)) |=> err);

    // R9: poll count never reaches the budget
    p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls < POLL_W'(MAX_POLLS));

endmodule

// File: tb/test_spi_erase_seq.sv
module test_spi_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int POLLS      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_block = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready, done, err, spi_cs_n, spi_sck, spi_si;
    logic        so_q = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_erase_seq #(
        .HALF_DIV (2), .CS_GAP (GAP), .MAX_POLLS (POLLS), .BLOCK_OPCODE (8'hD8)
    ) i_spi_erase_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_block (req_block), .req_addr (req_addr),
        .done (done), .err (err),
        .spi_cs_n (spi_cs_n), .spi_sck (spi_sck), .spi_si (spi_si), .spi_so (so_q)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // flash model
    int          busy_cfg = 0;
    logic [31:0] f_data = '0;
    int          f_bits = 0;
    logic        wel = 1'b0;
    int          busy_left = 0;
    int          wren_cnt = 0, erase_cnt = 0, erase_wel = 0, stat_cnt = 0, bad_cnt = 0;
    logic [7:0]  last_op = '0;
    logic [23:0] last_addr = '0;
    logic        rd_mode = 1'b0;
    logic [7:0]  stat_byte;

    assign stat_byte = {6'b0, wel, (busy_left > 0)};

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (f_bits == 8 && f_data[7:0] == 8'h06) begin
                wel = 1'b1;
                wren_cnt++;
            end else if (f_bits == 32) begin
                erase_cnt++;
                last_op   = f_data[31:24];
                last_addr = f_data[23:0];
                if (wel) erase_wel++;
                wel       = 1'b0;
                busy_left = busy_cfg;
            end else if (f_bits == 16 && f_data[15:8] == 8'h05) begin
                stat_cnt++;
                if (busy_left > 0) busy_left--;
            end else if (f_bits != 0) begin
                bad_cnt++;
            end
            f_bits = 0;
            f_data = '0;
        end else begin
            f_data = {f_data[30:0], spi_si};
            f_bits++;
        end
    end

    always @(negedge spi_sck) begin
        if (f_bits < 8)       rd_mode = 1'b0;
        else if (f_bits == 8) rd_mode = (f_data[7:0] == 8'h05);
        if (!spi_cs_n && rd_mode && f_bits >= 8 && f_bits < 16)
            so_q = stat_byte[15 - f_bits];
    end

    // bus monitor
    int   hi_run = 1000, gap_viol = 0, sck_bad = 0, done_total = 0;
    logic prev_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n === 1'b1 && spi_sck !== 1'b0) sck_bad++;
            if (spi_cs_n === 1'b1) hi_run++;
            else begin
                if (prev_cs && hi_run < GAP) gap_viol++;
                hi_run = 0;
            end
            prev_cs = spi_cs_n;
            if (done === 1'b1) done_total++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic blk, input logic [23:0] addr);
        @(negedge clk);
        req_valid = 1'b1;
        req_block = blk;
        req_addr  = addr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(output int cycles);
        cycles = 0;
        while (!req_ready && cycles < 20000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck after reset", spi_sck, 0);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(done == 1'b0 && err == 1'b0, "R1 done/err after reset", {done, err}, 0);
    endtask

    task automatic run_and_check(input logic blk, input logic [23:0] addr, input int busy,
                                 input logic [7:0] exp_op, input string name);
        int w0, e0, ew0, s0, b0, d0, g0, k0, cyc;
        w0 = wren_cnt; e0 = erase_cnt; ew0 = erase_wel; s0 = stat_cnt;
        b0 = bad_cnt; d0 = done_total; g0 = gap_viol; k0 = sck_bad;
        busy_cfg = busy;
        start_req(blk, addr);
        chk(req_ready == 1'b0, {"R2 ready low during ", name}, req_ready, 0);
        wait_end(cyc);
        chk(cyc < 20000, {"R2 sequence ends ", name}, cyc, 0);
        chk(wren_cnt - w0 == 1, {"R3 write-enable frame ", name}, wren_cnt - w0, 1);
        chk(erase_wel - ew0 == 1, {"R3 enable before erase ", name}, erase_wel - ew0, 1);
        chk(erase_cnt - e0 == 1, {"R4 one erase frame ", name}, erase_cnt - e0, 1);
        chk(last_op == exp_op, {"R4 erase opcode ", name}, last_op, exp_op);
        chk(last_addr == addr, {"R4 erase address ", name}, last_addr, addr);
        chk(stat_cnt - s0 == busy + 1, {"R5 status polls ", name}, stat_cnt - s0, busy + 1);
        chk(bad_cnt == b0, {"R5 frame lengths ", name}, bad_cnt - b0, 0);
        chk(sck_bad == k0, {"R6 sck idle low ", name}, sck_bad - k0, 0);
        chk(gap_viol == g0, {"R7 cs gap ", name}, gap_viol - g0, 0);
        chk(done_total - d0 == 1, {"R8 done pulse count ", name}, done_total - d0, 1);
        chk(err == 1'b0, {"R8 err low ", name}, err, 0);
    endtask

    task automatic t_sector;
        run_and_check(1'b0, 24'h5A3C71, 2, 8'h20, "sector");
    endtask

    task automatic t_block;
        run_and_check(1'b1, 24'hFFFFFF, 0, 8'hD8, "block");
        run_and_check(1'b0, 24'h000000, 1, 8'h20, "zero-addr");
    endtask

    task automatic t_ignore;
        int e0, w0, cyc;
        e0 = erase_cnt; w0 = wren_cnt;
        busy_cfg = 1;
        start_req(1'b0, 24'h123456);
        req_valid = 1'b1;
        req_block = 1'b1;
        req_addr  = 24'hABCDEF;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;
        wait_end(cyc);
        repeat (40) @(negedge clk);
        chk(erase_cnt - e0 == 1, "R2 extra request ignored", erase_cnt - e0, 1);
        chk(wren_cnt - w0 == 1, "R2 no second sequence", wren_cnt - w0, 1);
        chk(last_addr == 24'h123456, "R2 address kept", last_addr, 24'h123456);
        chk(last_op == 8'h20, "R2 opcode kept", last_op, 8'h20);
    endtask

    task automatic t_timeout;
        int s0, d0, cyc;
        s0 = stat_cnt; d0 = done_total;
        busy_cfg = 1000;
        start_req(1'b1, 24'h0F0000);
        wait_end(cyc);
        chk(err == 1'b1, "R9 err after budget", err, 1);
        chk(stat_cnt - s0 == POLLS, "R9 poll count at timeout", stat_cnt - s0, POLLS);
        chk(done_total == d0, "R9 no done on timeout", done_total - d0, 0);
        repeat (30) @(negedge clk);
        chk(err == 1'b1, "R9 err sticky", err, 1);
        chk(stat_cnt - s0 == POLLS, "R9 no polls after end", stat_cnt - s0, POLLS);
        chk(spi_cs_n == 1'b1, "R9 bus idle after end", spi_cs_n, 1);
    endtask

    task automatic t_err_clear;
        int d0, cyc;
        d0 = done_total;
        busy_cfg = 0;
        start_req(1'b0, 24'h00ABCD);
        chk(err == 1'b0, "R9 err cleared on accept", err, 0);
        wait_end(cyc);
        chk(done_total - d0 == 1, "R8 done after recovery", done_total - d0, 1);
        chk(last_addr == 24'h00ABCD, "R4 address after recovery", last_addr, 24'h00ABCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sector();
        t_block();
        t_ignore();
        t_timeout();
        t_err_clear();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule